// File: doc/BRIEF.md
# Multi-Mode Programmable Counter/Timer

This block is a 16-bit programmable down-counter for a serial controller. Software loads a preset through a byte-wide register port: one byte select addresses the low half and the other addresses the high half. A single divider core then does one of four jobs, picked by a mode input. It can generate a continuous square-wave clock. It can time a one-shot delay. It can count received characters. It can watch for a gap between received characters that is too long.

The count advances on a qualifying input clock enable (`tick_i`), or, in character-count mode, on a character-received pulse (`char_i`). Start and stop strobes arm and halt the core. When a serial channel takes `clk_o` as its clock source, it treats that clock as 16 times the bit rate. Reading either byte select returns the live count, not the stored preset. A preset of 1 is legal. A preset of 0 stands for 65536.

Top module: `ctr_timer_top`

## Requirements
- R1: After reset the live count is 0, `flag_o` is 0, `clk_o` is 0 and both preset bytes are 0.
- R2: A write with `reg_sel_i`=0 stores the preset bits 7:0, and a write with `reg_sel_i`=1 stores bits 15:8. `start_i` copies the 16-bit preset into the count. `reg_rdata_o` returns live count bits 7:0 for select 0 and bits 15:8 for select 1, with no delay.
- R3: Timer mode (`mode_i`=0): while running, each tick decrements the count. A tick that finds the count at 1 instead reloads the preset and toggles `clk_o`. Each half period is therefore n ticks, and a preset of 1 toggles on every tick. `flag_o` is set when `clk_o` falls.
- R4: Counter mode (`mode_i`=1): after n ticks from start, the count is 0, `flag_o` is set and the core halts.
- R5: Character-count mode (`mode_i`=2): each `char_i` decrements the count and `tick_i` has no effect. On the n-th character the count reaches 0, `flag_o` is set and the core halts.
- R6: Timeout mode (`mode_i`=3): each `char_i` reloads the preset, and `char_i` takes priority over `tick_i`. If n ticks pass with no character, `flag_o` is set, the count goes to 0 and the core halts.
- R7: `stop_i` halts the core and freezes the count, and it takes priority over `start_i`. Ticks and characters change nothing while the core is halted.
- R8: A preset of 0 acts as 65536, so in counter mode the flag rises after 65536 ticks.
- R9: Outside timer mode, `clk_o` does not change except when a start clears it.
- R10: `start_i` clears `flag_o` and `clk_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 timer, 1 counter, 2 character count, 3 timeout |
| reg_we_i | input | 1 | Preset byte write strobe |
| reg_sel_i | input | 1 | Byte select: 0 low, 1 high |
| reg_wdata_i | input | 8 | Preset byte write data |
| reg_rdata_o | output | 8 | Selected byte of the live count |
| start_i | input | 1 | Start command strobe |
| stop_i | input | 1 | Stop command strobe |
| tick_i | input | 1 | Input clock enable |
| char_i | input | 1 | Character-received pulse |
| clk_o | output | 1 | Square-wave output (16x clock in timer mode) |
| flag_o | output | 1 | Ready/interrupt flag |

## Verification
Every register in the core reaches a port. The count shows on `reg_rdata_o` through combinational logic. A wrong decrement or reload is therefore visible at the next sample after the edge that caused it. A wrong run state appears as a count that keeps moving after a stop, or one that freezes while running, and that shows within one tick or character. Errors in the flag or the wave show directly on `flag_o` and `clk_o`. The reference model is compared on every cycle, so a divergence is reported in the cycle where it first appears. It is not deferred to the end of the period.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_CHARS   = 2'd2,
    MODE_GAP     = 2'd3
  } ct_mode_e;
endpackage

// File: rtl/ct_preset_regs.sv
module ct_preset_regs #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  parameter int SEL_W  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [NB*BYTE_W-1:0] preset_o
);
  logic [BYTE_W-1:0] byte_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g)) byte_q[g] <= wdata_i;
    end
    assign preset_o[g*BYTE_W +: BYTE_W] = byte_q[g];
  end
endmodule

// File: rtl/ct_read_mux.sv
module ct_read_mux #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  parameter int SEL_W  = 1
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NB*BYTE_W-1:0] cnt_i,
  output logic [BYTE_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NB; i++)
      if (sel_i == SEL_W'(i)) rdata_o = cnt_i[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ct_mode_e         mode_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic             char_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wave_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             run_q, wave_q, flag_q, last;

  assign cnt_dec = cnt_q - CNT_W'(1);
  assign last    = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= preset_i;
      run_q  <= 1'b1;
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (run_q) begin
      unique case (mode_i)
        MODE_TIMER: if (tick_i) begin
          if (last) begin
            cnt_q  <= preset_i;
            wave_q <= ~wave_q;
            if (wave_q) flag_q <= 1'b1;  // falling edge ends a period
          end else cnt_q <= cnt_dec;
        end
        MODE_ONESHOT: if (tick_i) begin
          if (last) begin
            cnt_q <= '0; run_q <= 1'b0; flag_q <= 1'b1;
          end else cnt_q <= cnt_dec;
        end
        MODE_CHARS: if (char_i) begin
          if (last) begin
            cnt_q <= '0; run_q <= 1'b0; flag_q <= 1'b1;
          end else cnt_q <= cnt_dec;
        end
        MODE_GAP: begin
          if (char_i) cnt_q <= preset_i;
          else if (tick_i) begin
            if (last) begin
              cnt_q <= '0; run_q <= 1'b0; flag_q <= 1'b1;
            end else cnt_q <= cnt_dec;
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign wave_o = wave_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ctr_timer_top.sv
module ctr_timer_top
  import ct_pkg::*;
#(
  parameter int  CNT_W  = 16,
  parameter int  BYTE_W = 8,
  localparam int NB     = CNT_W / BYTE_W,
  localparam int SEL_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              reg_we_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  input  logic              char_i,
  output logic              clk_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] preset_w, cnt_w;
  logic             run_w;

  ct_preset_regs #(.BYTE_W(BYTE_W), .NB(NB), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i     (reg_we_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .preset_o (preset_w)
  );

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni,
    .mode_i   (ct_mode_e'(mode_i)),
    .start_i, .stop_i, .tick_i, .char_i,
    .preset_i (preset_w),
    .cnt_o    (cnt_w),
    .run_o    (run_w),
    .wave_o   (clk_o),
    .flag_o   (flag_o)
  );

  ct_read_mux #(.BYTE_W(BYTE_W), .NB(NB), .SEL_W(SEL_W)) u_rd (
    .sel_i   (reg_sel_i),
    .cnt_i   (cnt_w),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/ct_timer_chk.sv
module ct_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             start_i,
  input logic             stop_i,
  input logic             tick_i,
  input logic             char_i,
  input logic             clk_o,
  input logic             flag_o,
  input logic [CNT_W-1:0] cnt,
  input logic             run,
  input logic [CNT_W-1:0] preset
);
  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (!flag_o && !clk_o));

  assert_stop_freezes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt == $past(cnt) && !run));

  assert_wave_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd0 && !start_i) |=> $stable(clk_o));

  assert_tick_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && !char_i && !start_i) |=> $stable(cnt));

  assert_preset1_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && run && tick_i && preset == CNT_W'(1) && cnt == CNT_W'(1)
     && !start_i && !stop_i) |=> (clk_o != $past(clk_o)));

  assert_expiry_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && $rose(flag_o)) |-> (cnt == '0 && !run));

  assert_gap_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3 && run && char_i && !start_i && !stop_i) |=> (cnt == $past(preset)));
endmodule

bind ctr_timer_top ct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .mode_i, .start_i, .stop_i, .tick_i, .char_i,
  .clk_o, .flag_o,
  .cnt    (cnt_w),
  .run    (run_w),
  .preset (preset_w)
);

// File: tb/ctr_timer_top_tb_top.sv
`timescale 1ns/100ps
module ctr_timer_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       start_i = 1'b0, stop_i = 1'b0, tick_i = 1'b0, char_i = 1'b0;
  logic       clk_o, flag_o;

  int    errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ctr_timer_top dut_i (.*);

  // behavioural reference
  int m_cnt, m_lo, m_hi, m_pv;
  bit m_run, m_wave, m_flag;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_lo = 0; m_hi = 0; m_run = 0; m_wave = 0; m_flag = 0;
    end else begin
      cycles++;
      m_pv = m_hi * 256 + m_lo;
      if (stop_i) m_run = 0;
      else if (start_i) begin
        m_cnt = m_pv; m_run = 1; m_wave = 0; m_flag = 0;
      end else if (m_run) begin
        if (mode_i == 2'd3 && char_i) m_cnt = m_pv;
        else if ((mode_i == 2'd2 && char_i) || (mode_i != 2'd2 && tick_i)) begin
          if (m_cnt == 1) begin
            if (mode_i == 2'd0) begin
              m_cnt = m_pv;
              if (m_wave) m_flag = 1;
              m_wave = !m_wave;
            end else begin
              m_cnt = 0; m_run = 0; m_flag = 1;
            end
          end else m_cnt = (m_cnt + 65535) % 65536;
        end
      end
      if (reg_we_i) begin
        if (reg_sel_i) m_hi = reg_wdata_i; else m_lo = reg_wdata_i;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int exp_rd;
      exp_rd = reg_sel_i ? (m_cnt / 256) : (m_cnt % 256);
      checks += 3;
      if (reg_rdata_o !== 8'(exp_rd)) begin
        errors++;
        $display("FAIL %s rdata sel=%0d got %0d exp %0d", cur_req, reg_sel_i, reg_rdata_o, exp_rd);
      end
      if (flag_o !== m_flag) begin
        errors++;
        $display("FAIL %s flag_o got %0b exp %0b", cur_req, flag_o, m_flag);
      end
      if (clk_o !== m_wave) begin
        errors++;
        $display("FAIL %s clk_o got %0b exp %0b", cur_req, clk_o, m_wave);
      end
    end
  end

  task automatic drive(bit we, bit sel, int wd, bit st, bit sp, bit tk, bit ch);
    @(negedge clk_i); #1;
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = 8'(wd);
    start_i = st; stop_i = sp; tick_i = tk; char_i = ch;
  endtask

  task automatic idle(int n, bit sel = 0);
    for (int i = 0; i < n; i++) drive(0, sel, 0, 0, 0, 0, 0);
  endtask

  task automatic ticks(int n, bit sel = 0);
    for (int i = 0; i < n; i++) drive(0, sel, 0, 0, 0, 1, 0);
  endtask

  task automatic chars(int n, bit tk = 0);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, tk, 1);
  endtask

  task automatic load(int val);
    drive(1, 0, val % 256, 0, 0, 0, 0);
    drive(1, 1, val / 256, 0, 0, 0, 0);
  endtask

  task automatic go();
    drive(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    // reset state R1
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cur_req = "R1";
    idle(3); idle(2, 1);

    // timer mode, preset 3, R2 and R3
    cur_req = "R3"; mode_i = 2'd0;
    load(3); go(); ticks(20); ticks(5, 1);
    // timer preset 1 toggles every tick
    load(1); go(); ticks(9);

    // stop freezes, stop beats start R7
    cur_req = "R7";
    load(5); go(); ticks(3);
    drive(0, 0, 0, 0, 1, 1, 0); ticks(6); chars(2);
    drive(0, 0, 0, 1, 1, 0, 0); ticks(3);

    // counter one-shot, preset 0x0105 R4 and R2 upper byte readback
    cur_req = "R4"; mode_i = 2'd1;
    load(16'h0105); go(); ticks(100, 1); ticks(170);
    cur_req = "R9"; ticks(5); idle(2);

    // restart clears flag R10
    cur_req = "R10"; go(); idle(3);

    // character count R5
    cur_req = "R5"; mode_i = 2'd2;
    load(4); go(); ticks(10); chars(2); ticks(3); chars(3); idle(2);

    // timeout R6
    cur_req = "R6"; mode_i = 2'd3;
    load(6); go(); ticks(4); chars(1, 1); ticks(5); chars(1); ticks(10);
    go(); ticks(2); chars(1); idle(2);

    // preset zero means 65536 R8
    cur_req = "R8"; mode_i = 2'd1;
    load(0); go(); ticks(65535); ticks(3, 1); idle(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(180000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired in %s after %0d cycles", cur_req, cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule